// File: doc/BRIEF.md
# Round-Robin Wavefront Issue Scheduler

This block keeps a pool of resident wavefronts for one SIMD execution pipe and picks, on every clock, at most one wave to issue an instruction. A wave can be picked when its slot is occupied, its operands are present and it is not still paying for its previous instruction. Each issued instruction charges the wave a busy time that depends on its class. The charge is scaled by the number of clocks a full wave needs to pass through the narrower lane array. With 64 elements and 16 lanes that is 4 clocks per instruction cycle.

Selection is round-robin. The search starts at the slot after the one that issued last and wraps past the top of the pool. Waves that are stalled for data or still busy are passed over, so the pipe stays fed while any wave can go. Waves enter through an allocate port that hands out the lowest free slot. They leave through a retire port that names a slot. Each slot has an operand-ready input and a 2-bit instruction-class input. The issue output gives the chosen slot and the class it carries.

Top module: `wave_issue_sched`

## Requirements
- R1: After reset no slot is occupied, `issue_valid` is 0, and an allocate request is granted slot 0.
- R2: When `alloc_req` is high and a slot is free, `alloc_grant` is high and `alloc_slot` names the lowest-numbered free slot. That slot is occupied from the next clock.
- R3: When every slot is occupied, `alloc_grant` stays 0. A later retire makes a slot grantable again.
- R4: A retire clears the named slot at the next clock. The slot is then never issued, and it becomes the lowest free slot if no lower one is free.
- R5: A slot can be issued only when it is occupied, its `opnd_ready` bit is 1 and its busy countdown is zero. When no slot qualifies, `issue_valid` is 0.
- R6: The search for the next issue starts at the slot one above the last issued slot and wraps from the highest slot to slot 0.
- R7: Class encoding 0 (simple) costs 1 instruction cycle. A lone ready wave issuing simple instructions issues once every 4 clocks. Encoding 3 is treated as simple.
- R8: Class encoding 1 (complex) costs 4 instruction cycles, so the wave issues again 16 clocks after it last issued.
- R9: Class encoding 2 (branch) costs 16 instruction cycles, so the wave issues again 64 clocks after it last issued.
- R10: A wave that lacks operands is skipped. In the same clock the next qualifying wave in round-robin order is issued.
- R11: While nothing issues, the last-issued pointer holds. The pointer is cleared to slot 0 by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a free slot for a new wave |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_slot | output | 5 | Slot index handed to the new wave |
| retire_valid | input | 1 | Release a slot this cycle |
| retire_slot | input | 5 | Slot index to release |
| opnd_ready | input | 32 | One bit per slot: operands present |
| instr_class | input | 64 | Two bits per slot, slot i at bits 2i+1:2i: class of its next instruction |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_slot | output | 5 | Slot that issues |
| issue_class | output | 2 | Class of the issued instruction |

## Verification
The bound checker watches every cycle for the safety rules. Only slots with operands present may issue. No grant is made when the pool is full or to a slot already occupied. A granted slot is occupied one clock later, and a retired slot is free one clock later. The pipe never idles while some slot is occupied, operand-ready and not busy. When nothing issues, the pointer stays put. The directed scenarios cover what depends on history and order: the exact round-robin sequence with wrap-around, the 4, 16 and 64 clock re-issue distances of the three classes, the skip of a stalled wave, lowest-free allocation after a retire, and refusal followed by recovery when the pool fills.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

    typedef enum logic [1:0] {
        CLS_SIMPLE  = 2'd0,
        CLS_COMPLEX = 2'd1,
        CLS_BRANCH  = 2'd2,
        CLS_RSVD    = 2'd3
    } instr_cls_e;

    localparam int unsigned ICYC_SIMPLE  = 1;
    localparam int unsigned ICYC_COMPLEX = 4;
    localparam int unsigned ICYC_BRANCH  = 16;

    // Instruction cycles charged for one instruction of a class.
    function automatic int unsigned cls_icycles(instr_cls_e c);
        case (c)
            CLS_COMPLEX: return ICYC_COMPLEX;
            CLS_BRANCH:  return ICYC_BRANCH;
            default:     return ICYC_SIMPLE;
        endcase
    endfunction

    // Per-issue bookkeeping request handed to the slot table.
    typedef struct packed {
        logic       fire;
        instr_cls_e cls;
    } issue_req_t;

endpackage

// File: rtl/wsched_slot_table.sv
module wsched_slot_table
    import wsched_pkg::*;
#(
    parameter int unsigned NUM_SLOTS    = 32,
    parameter int unsigned IDX_W        = 5,
    parameter int unsigned CNT_W        = 7,
    parameter int unsigned CLK_PER_ICYC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_en,
    input  logic [IDX_W-1:0]     alloc_idx,
    input  logic                 retire_en,
    input  logic [IDX_W-1:0]     retire_idx,
    input  issue_req_t           issue_req,
    input  logic [IDX_W-1:0]     issue_idx,
    output logic [NUM_SLOTS-1:0] vld,
    output logic [NUM_SLOTS-1:0] cnt_zero
);

    // Countdown load: the wave may issue again exactly cost clocks later.
    logic [CNT_W-1:0] load_val;
    always_comb begin
        load_val = CNT_W'(cls_icycles(issue_req.cls) * CLK_PER_ICYC - 1);
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [CNT_W-1:0] cnt_q;
        logic             vld_q;
        logic             hit_alloc, hit_retire, hit_issue;

        always_comb begin
            hit_alloc  = alloc_en  && (alloc_idx  == IDX_W'(i));
            hit_retire = retire_en && (retire_idx == IDX_W'(i));
            hit_issue  = issue_req.fire && (issue_idx == IDX_W'(i));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
                cnt_q <= '0;
            end else if (hit_alloc) begin
                vld_q <= 1'b1;
                cnt_q <= '0;
            end else if (hit_retire) begin
                vld_q <= 1'b0;
                cnt_q <= '0;
            end else if (hit_issue) begin
                cnt_q <= load_val;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign vld[i]      = vld_q;
        assign cnt_zero[i] = (cnt_q == '0);
    end

endmodule

// File: rtl/wsched_free_finder.sv
module wsched_free_finder #(
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [NUM_SLOTS-1:0] vld,
    output logic                 any_free,
    output logic [IDX_W-1:0]     free_idx
);

    // Lowest-numbered unoccupied slot.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (!vld[k]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/wsched_rr_picker.sv
module wsched_rr_picker #(
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [NUM_SLOTS-1:0] elig,
    input  logic [IDX_W-1:0]     last_idx,
    output logic                 pick_valid,
    output logic [IDX_W-1:0]     pick_idx
);

    // Scan offsets 1..NUM_SLOTS from the last issued slot; the last slot
    // checked is the last issued one itself, so it has lowest priority.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int k = 1; k <= NUM_SLOTS; k++) begin
            int j;
            j = int'(last_idx) + k;
            if (j >= int'(NUM_SLOTS)) j = j - int'(NUM_SLOTS);
            if (!pick_valid && elig[j]) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
    import wsched_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = 32,
    parameter int unsigned WAVE_ELEMS = 64,
    parameter int unsigned SIMD_LANES = 16,
    localparam int unsigned IDX_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int unsigned CLK_PER_ICYC = WAVE_ELEMS / SIMD_LANES,
    localparam int unsigned MAX_COST     = ICYC_BRANCH * CLK_PER_ICYC,
    localparam int unsigned CNT_W        = $clog2(MAX_COST + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_req,
    output logic                   alloc_grant,
    output logic [IDX_W-1:0]       alloc_slot,
    input  logic                   retire_valid,
    input  logic [IDX_W-1:0]       retire_slot,
    input  logic [NUM_SLOTS-1:0]   opnd_ready,
    input  logic [2*NUM_SLOTS-1:0] instr_class,
    output logic                   issue_valid,
    output logic [IDX_W-1:0]       issue_slot,
    output logic [1:0]             issue_class
);

    logic [NUM_SLOTS-1:0] vld;
    logic [NUM_SLOTS-1:0] cnt_zero;
    logic [NUM_SLOTS-1:0] elig;
    logic [IDX_W-1:0]     ptr;
    logic                 any_free;
    logic                 pick_valid;
    logic [IDX_W-1:0]     pick_idx;
    instr_cls_e           pick_cls;
    issue_req_t           issue_req;

    assign elig = vld & opnd_ready & cnt_zero;

    wsched_free_finder #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_free (
        .vld      (vld),
        .any_free (any_free),
        .free_idx (alloc_slot)
    );

    wsched_rr_picker #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_pick (
        .elig       (elig),
        .last_idx   (ptr),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    assign alloc_grant = alloc_req && any_free;
    assign pick_cls    = instr_cls_e'(instr_class[pick_idx*2 +: 2]);

    always_comb begin
        issue_req.fire = pick_valid;
        issue_req.cls  = pick_cls;
    end

    wsched_slot_table #(
        .NUM_SLOTS    (NUM_SLOTS),
        .IDX_W        (IDX_W),
        .CNT_W        (CNT_W),
        .CLK_PER_ICYC (CLK_PER_ICYC)
    ) u_tab (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (alloc_grant),
        .alloc_idx  (alloc_slot),
        .retire_en  (retire_valid),
        .retire_idx (retire_slot),
        .issue_req  (issue_req),
        .issue_idx  (pick_idx),
        .vld        (vld),
        .cnt_zero   (cnt_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (pick_valid) begin
            ptr <= pick_idx;
        end
    end

    assign issue_valid = pick_valid;
    assign issue_slot  = pick_idx;
    assign issue_class = pick_cls;

endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 alloc_grant,
    input logic [IDX_W-1:0]     alloc_slot,
    input logic                 retire_valid,
    input logic [IDX_W-1:0]     retire_slot,
    input logic [NUM_SLOTS-1:0] opnd_ready,
    input logic                 issue_valid,
    input logic [IDX_W-1:0]     issue_slot,
    input logic [NUM_SLOTS-1:0] vld,
    input logic [NUM_SLOTS-1:0] cnt_zero,
    input logic [IDX_W-1:0]     ptr
);

    assert_grant_free_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_grant |-> !vld[alloc_slot]);

    assert_grant_occupies_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_grant |=> vld[$past(alloc_slot)]);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (&vld) |-> !alloc_grant);

    assert_retire_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && !(alloc_grant && alloc_slot == retire_slot))
            |=> !vld[$past(retire_slot)]);

    assert_issue_ready_R5: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (opnd_ready[issue_slot] && vld[issue_slot]));

    assert_no_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (|(vld & opnd_ready & cnt_zero)) |-> issue_valid);

    assert_ptr_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> $stable(ptr));

endmodule

bind wave_issue_sched wave_issue_sched_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .alloc_grant  (alloc_grant),
    .alloc_slot   (alloc_slot),
    .retire_valid (retire_valid),
    .retire_slot  (retire_slot),
    .opnd_ready   (opnd_ready),
    .issue_valid  (issue_valid),
    .issue_slot   (issue_slot),
    .vld          (vld),
    .cnt_zero     (cnt_zero),
    .ptr          (ptr)
);

// File: tb/wave_issue_sched_tb.sv
module wave_issue_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          alloc_req;
    logic          alloc_grant;
    logic [4:0]    alloc_slot;
    logic          retire_valid;
    logic [4:0]    retire_slot;
    logic [N-1:0]  opnd_ready;
    logic [2*N-1:0] instr_class;
    logic          issue_valid;
    logic [4:0]    issue_slot;
    logic [1:0]    issue_class;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_issue_sched u_dut (
        .clk          (clk),
        .rst          (rst),
        .alloc_req    (alloc_req),
        .alloc_grant  (alloc_grant),
        .alloc_slot   (alloc_slot),
        .retire_valid (retire_valid),
        .retire_slot  (retire_slot),
        .opnd_ready   (opnd_ready),
        .instr_class  (instr_class),
        .issue_valid  (issue_valid),
        .issue_slot   (issue_slot),
        .issue_class  (issue_class)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic alloc_expect(input int exp, input string req);
        alloc_req = 1'b1;
        #1;
        check(alloc_grant == 1'b1, {req, " grant"}, int'(alloc_grant), 1);
        check(int'(alloc_slot) == exp, {req, " slot"}, int'(alloc_slot), exp);
        tick();
        alloc_req = 1'b0;
    endtask

    task automatic expect_issue(input int exp, input string req);
        #1;
        check(issue_valid == 1'b1, {req, " valid"}, int'(issue_valid), 1);
        check(int'(issue_slot) == exp, {req, " slot"}, int'(issue_slot), exp);
    endtask

    // R1: reset state
    task automatic t_reset();
        #1;
        check(issue_valid == 1'b0, "R1 idle", int'(issue_valid), 0);
        alloc_req = 1'b1;
        #1;
        check(alloc_grant == 1'b1 && alloc_slot == 5'd0, "R1 first slot",
              int'(alloc_slot), 0);
        alloc_req = 1'b0;
        #1;
    endtask

    // R2: lowest-free allocation
    task automatic t_alloc4();
        for (int s = 0; s < 4; s++) alloc_expect(s, "R2");
    endtask

    // R6 order with wrap, R7 simple re-issue distance
    task automatic t_round_robin();
        instr_class = '0;
        opnd_ready  = 32'h0000_000F;
        expect_issue(1, "R6 first");
        tick();
        expect_issue(2, "R6 second");
        tick();
        expect_issue(3, "R6 third");
        tick();
        expect_issue(0, "R6 wrap");
        tick();
        expect_issue(1, "R7 simple again after 4");
        opnd_ready = '0;
        #1;
    endtask

    // R5 idle, R11 pointer hold, R10 stalled wave skipped
    task automatic t_hold_skip();
        repeat (8) tick();
        check(issue_valid == 1'b0, "R5 none ready", int'(issue_valid), 0);
        opnd_ready = 32'h0000_000F;
        expect_issue(1, "R11 pointer held at 0");
        opnd_ready = 32'h0000_000D;
        expect_issue(2, "R10 skip stalled slot 1");
        opnd_ready = '0;
        #1;
    endtask

    task automatic t_period(input logic [1:0] cls, input int exp, input string req);
        int n;
        instr_class[1:0] = cls;
        opnd_ready = 32'h0000_0001;
        expect_issue(0, {req, " first"});
        tick();
        n = 1;
        while (!issue_valid && n < 200) begin
            tick();
            n++;
        end
        check(n == exp, {req, " distance"}, n, exp);
        opnd_ready = '0;
        instr_class = '0;
        #1;
    endtask

    // R4 retire
    task automatic t_retire();
        retire_valid = 1'b1;
        retire_slot  = 5'd2;
        tick();
        retire_valid = 1'b0;
        opnd_ready = 32'h0000_0004;
        #1;
        check(issue_valid == 1'b0, "R4 retired not issued", int'(issue_valid), 0);
        alloc_req = 1'b1;
        #1;
        check(int'(alloc_slot) == 2, "R4 lowest free", int'(alloc_slot), 2);
        alloc_req = 1'b0;
        opnd_ready = '0;
        #1;
    endtask

    // R3 full pool
    task automatic t_full();
        alloc_expect(2, "R3 fill");
        for (int s = 4; s < N; s++) alloc_expect(s, "R3 fill");
        alloc_req = 1'b1;
        #1;
        check(alloc_grant == 1'b0, "R3 refused when full", int'(alloc_grant), 0);
        tick();
        alloc_req = 1'b0;
        retire_valid = 1'b1;
        retire_slot  = 5'd31;
        tick();
        retire_valid = 1'b0;
        alloc_expect(31, "R3 regrant after retire");
    endtask

    initial begin
        rst = 1'b1;
        alloc_req = 1'b0;
        retire_valid = 1'b0;
        retire_slot = '0;
        opnd_ready = '0;
        instr_class = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_alloc4();
        t_round_robin();
        t_hold_skip();
        t_period(2'd0, 4, "R7 simple");
        t_period(2'd3, 4, "R7 reserved as simple");
        t_period(2'd1, 16, "R8 complex");
        t_period(2'd2, 64, "R9 branch");
        t_retire();
        t_full();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule